// File: doc/BRIEF.md
# In-Place Exchange Sorter

This block owns a small single-port memory of unsigned words and puts its contents into ascending order without any second buffer. Before a run, the surrounding logic fills the memory word by word through a load port. It then pulses or holds `start`. After `done` rises, it reads the ordered words back through a read port.

The sort works as a pair of nested loops. An outer position `i` walks from the first word to the next-to-last word. For each `i`, the word at `i` is held in a register. An inner position `j` then scans every later word. Whenever the held word is strictly greater than the scanned word, the two are exchanged in memory. The held word then takes the smaller value. Every read and every write of the run shares the one memory port. An address multiplexer chooses `i` or `j`, and a data multiplexer chooses which held register is written.

The controller is split into an outer state machine and an inner state machine. The outer machine sets up each position and hands the scan to the inner machine. It waits for the inner machine's finish strobe and then advances or finishes.

Top module: `exch_sorter`

## Requirements
- R1: After `done` rises, the DEPTH words in memory are in non-decreasing unsigned order and are a permutation of the words present when the run began.
- R2: Two equal words are never exchanged. A memory whose words are all equal finishes in exactly the same number of cycles as one that is already ordered.
- R3: `done` rises exactly 2(DEPTH-1) + 3·DEPTH(DEPTH-1)/2 + 2·S clock edges after the edge that samples `start`. S is the number of exchanges, and each exchange takes two write cycles: first to position `i`, then to position `j`.
- R4: While `start` stays high after completion, `done` stays high. The first edge that samples `start` low clears `done`.
- R5: While no run is active, `ld_we` high writes `ld_data` into word `ld_addr` at the next edge. A read presented on `rd_addr` appears on `rd_data` two edges later.
- R6: `ld_we` asserted while a run is active writes nothing into the memory.
- R7: `rd_data` does not change while a run is active, whatever `rd_addr` does.
- R8: A load presented in the same cycle as `start` is accepted, and that word takes part in the run.
- R9: After reset, `done` is low and `rd_data` is zero.
- R10: A second `start` after a completed run sorts the memory's current contents again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle; level also governs release of `done` |
| done | output | 1 | High from completion until `start` is seen low |
| ld_we | input | 1 | Load strobe for one memory word |
| ld_addr | input | $clog2(DEPTH) | Word index to load |
| ld_data | input | WIDTH | Word value to load |
| rd_addr | input | $clog2(DEPTH) | Word index to read |
| rd_data | output | WIDTH | Registered read result |

## Verification
The memory port is claimed by two functions that can meet in one cycle: the external load/read path and the sorter's own accesses. The bench raises `ld_we` together with `start` and expects the loaded word to appear in the ordered result. It also drives loads and sweeps `rd_addr` in the middle of a run and expects the final contents to match the untouched input and `rd_data` to stay frozen. Each run's length is compared against the exchange count of a reference model, so a missing or extra write cycle shows up even when the final order is right.

// File: rtl/sort_pkg.sv
package sort_pkg;
  typedef enum logic [2:0] {
    OS_IDLE,
    OS_ADDR_I,
    OS_TAKE_A,
    OS_SCAN,
    OS_FINISH
  } outer_st_t;

  typedef enum logic [2:0] {
    IS_IDLE,
    IS_ADDR_J,
    IS_TAKE_B,
    IS_CMP,
    IS_WR_I,
    IS_WR_J
  } inner_st_t;
endpackage

// File: rtl/sort_mem.sv
module sort_mem #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wd,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] ram [DEPTH];

  // read-first single port, registered output: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) ram[addr] <= wd;
    q <= ram[addr];
  end
endmodule

// File: rtl/sort_datapath.sv
module sort_datapath #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic             en_i,
  input  logic             en_j,
  input  logic             inc_from_j,
  input  logic             en_a,
  input  logic             a_from_b,
  input  logic             en_b,
  input  logic             addr_pick_j,
  input  logic             wd_pick_a,
  input  logic [WIDTH-1:0] mem_q,
  output logic [AW-1:0]    int_addr,
  output logic [WIDTH-1:0] int_wd,
  output logic             a_gt_b,
  output logic             i_at_end,
  output logic             j_at_end,
  output logic [AW-1:0]    i_q,
  output logic [AW-1:0]    j_q
);
  localparam logic [AW-1:0] I_END = AW'(DEPTH - 2);
  localparam logic [AW-1:0] J_END = AW'(DEPTH - 1);

  logic [WIDTH-1:0] a_q, b_q;
  logic [AW-1:0]    bumped;

  // one shared incrementor, its source picked by a mux
  assign bumped = (inc_from_j ? j_q : i_q) + AW'(1);

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      i_q <= '0;
      j_q <= '0;
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (en_i) i_q <= bumped;
      if (en_j) j_q <= bumped;
      if (en_a) a_q <= a_from_b ? b_q : mem_q;
      if (en_b) b_q <= mem_q;
    end
  end

  assign int_addr = addr_pick_j ? j_q : i_q;
  assign int_wd   = wd_pick_a ? a_q : b_q;
  assign a_gt_b   = a_q > b_q;
  assign i_at_end = (i_q == I_END);
  assign j_at_end = (j_q == J_END);

  // R1: the position being written by an index update never wraps
  assert_index_no_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (en_j && inc_from_j) |-> (j_q != J_END));
endmodule

// File: rtl/sort_inner_fsm.sv
module sort_inner_fsm
  import sort_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic a_gt_b,
  input  logic j_at_end,
  output logic fin,
  output logic running,
  output logic inc_j,
  output logic en_b,
  output logic load_a_from_b,
  output logic addr_pick_j,
  output logic wd_pick_a,
  output logic mem_we
);
  inner_st_t st, st_nx;

  always_ff @(posedge clk) begin
    if (rst) st <= IS_IDLE;
    else     st <= st_nx;
  end

  always_comb begin
    st_nx         = st;
    fin           = 1'b0;
    inc_j         = 1'b0;
    en_b          = 1'b0;
    load_a_from_b = 1'b0;
    addr_pick_j   = 1'b0;
    wd_pick_a     = 1'b0;
    mem_we        = 1'b0;
    unique case (st)
      IS_IDLE: if (go) st_nx = IS_ADDR_J;
      IS_ADDR_J: begin
        addr_pick_j = 1'b1;
        st_nx       = IS_TAKE_B;
      end
      IS_TAKE_B: begin
        en_b  = 1'b1;
        st_nx = IS_CMP;
      end
      IS_CMP: begin
        if (a_gt_b) begin
          st_nx = IS_WR_I;
        end else if (j_at_end) begin
          fin   = 1'b1;
          st_nx = IS_IDLE;
        end else begin
          inc_j = 1'b1;
          st_nx = IS_ADDR_J;
        end
      end
      IS_WR_I: begin
        mem_we = 1'b1;
        st_nx  = IS_WR_J;
      end
      IS_WR_J: begin
        mem_we        = 1'b1;
        addr_pick_j   = 1'b1;
        wd_pick_a     = 1'b1;
        load_a_from_b = 1'b1;
        if (j_at_end) begin
          fin   = 1'b1;
          st_nx = IS_IDLE;
        end else begin
          inc_j = 1'b1;
          st_nx = IS_ADDR_J;
        end
      end
      default: st_nx = IS_IDLE;
    endcase
  end

  assign running = (st != IS_IDLE);

  // R3: an exchange writes position i first, then position j
  assert_swap_i_then_j_R3: assert property (@(posedge clk) disable iff (rst)
    (st == IS_WR_I) |=> (st == IS_WR_J));
  assert_swap_j_after_i_R3: assert property (@(posedge clk) disable iff (rst)
    (st == IS_WR_J) |-> ($past(st) == IS_WR_I));
  // R2: no exchange unless the held word is strictly greater
  assert_equal_no_swap_R2: assert property (@(posedge clk) disable iff (rst)
    (st == IS_CMP && !a_gt_b) |=> (st != IS_WR_I));
endmodule

// File: rtl/sort_outer_fsm.sv
module sort_outer_fsm
  import sort_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic inner_fin,
  input  logic i_at_end,
  output logic clr_all,
  output logic en_i,
  output logic en_a_mem,
  output logic set_j,
  output logic inner_go,
  output logic busy,
  output logic done
);
  outer_st_t st, st_nx;

  always_ff @(posedge clk) begin
    if (rst) st <= OS_IDLE;
    else     st <= st_nx;
  end

  always_comb begin
    st_nx    = st;
    clr_all  = 1'b0;
    en_i     = 1'b0;
    en_a_mem = 1'b0;
    set_j    = 1'b0;
    inner_go = 1'b0;
    unique case (st)
      OS_IDLE: if (start) begin
        clr_all = 1'b1;
        st_nx   = OS_ADDR_I;
      end
      OS_ADDR_I: st_nx = OS_TAKE_A;
      OS_TAKE_A: begin
        en_a_mem = 1'b1;
        set_j    = 1'b1;
        inner_go = 1'b1;
        st_nx    = OS_SCAN;
      end
      OS_SCAN: if (inner_fin) begin
        if (i_at_end) begin
          st_nx = OS_FINISH;
        end else begin
          en_i  = 1'b1;
          st_nx = OS_ADDR_I;
        end
      end
      OS_FINISH: if (!start) st_nx = OS_IDLE;
      default: st_nx = OS_IDLE;
    endcase
  end

  assign busy = (st == OS_ADDR_I) || (st == OS_TAKE_A) || (st == OS_SCAN);
  assign done = (st == OS_FINISH);

  // R4: done is released only by start going low, and then at once
  assert_done_release_R4: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !done);
  assert_done_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> done);
endmodule

// File: rtl/exch_sorter.sv
module exch_sorter #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             done,
  input  logic             ld_we,
  input  logic [AW-1:0]    ld_addr,
  input  logic [WIDTH-1:0] ld_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic             clr_all, o_en_i, o_en_a, o_set_j, inner_go, busy;
  logic             inner_fin, inner_run, n_inc_j, n_en_b, n_a_from_b;
  logic             n_addr_j, n_wd_a, n_we;
  logic             a_gt_b, i_at_end, j_at_end;
  logic [AW-1:0]    int_addr, i_q, j_q;
  logic [WIDTH-1:0] int_wd, mem_q;
  logic             mem_we;
  logic [AW-1:0]    mem_addr;
  logic [WIDTH-1:0] mem_wd;
  logic             rd_pend;

  sort_outer_fsm u_outer (
    .clk(clk), .rst(rst), .start(start), .inner_fin(inner_fin),
    .i_at_end(i_at_end), .clr_all(clr_all), .en_i(o_en_i),
    .en_a_mem(o_en_a), .set_j(o_set_j), .inner_go(inner_go),
    .busy(busy), .done(done)
  );

  sort_inner_fsm u_inner (
    .clk(clk), .rst(rst), .go(inner_go), .a_gt_b(a_gt_b),
    .j_at_end(j_at_end), .fin(inner_fin), .running(inner_run),
    .inc_j(n_inc_j), .en_b(n_en_b), .load_a_from_b(n_a_from_b),
    .addr_pick_j(n_addr_j), .wd_pick_a(n_wd_a), .mem_we(n_we)
  );

  sort_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst(rst), .clr_all(clr_all), .en_i(o_en_i),
    .en_j(o_set_j | n_inc_j), .inc_from_j(n_inc_j),
    .en_a(o_en_a | n_a_from_b), .a_from_b(n_a_from_b), .en_b(n_en_b),
    .addr_pick_j(n_addr_j), .wd_pick_a(n_wd_a), .mem_q(mem_q),
    .int_addr(int_addr), .int_wd(int_wd), .a_gt_b(a_gt_b),
    .i_at_end(i_at_end), .j_at_end(j_at_end), .i_q(i_q), .j_q(j_q)
  );

  // the one memory port: the sorter owns it while busy, the outside otherwise
  always_comb begin
    if (busy) begin
      mem_we   = n_we;
      mem_addr = int_addr;
      mem_wd   = int_wd;
    end else begin
      mem_we   = ld_we;
      mem_addr = ld_we ? ld_addr : rd_addr;
      mem_wd   = ld_data;
    end
  end

  sort_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wd(mem_wd), .q(mem_q)
  );

  // capture only reads that were issued from the outside
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_pend <= !busy;
      if (rd_pend) rd_data <= mem_q;
    end
  end

  // R7: the read result is frozen once a run is under way
  assert_read_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && $past(busy, 2)) |-> $stable(rd_data));
  // R1: the scan position always lies past the held position
  assert_scan_after_hold_R1: assert property (@(posedge clk) disable iff (rst)
    inner_run |-> (j_q > i_q));
  // R6: no write reaches the memory from outside during a run
  assert_no_load_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !inner_run) |-> !mem_we);
endmodule

// File: tb/exch_sorter_bench.sv
module exch_sorter_bench;
  localparam int W  = 8;
  localparam int K  = 8;
  localparam int AW = $clog2(K);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          done;
  logic          ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [W-1:0]  ld_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [W-1:0]  rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [W-1:0] pat [K];
  logic [W-1:0] ref_m [K];
  int           ref_swaps;

  exch_sorter #(.WIDTH(W), .DEPTH(K)) u_exch_sorter (
    .clk(clk), .rst(rst), .start(start), .done(done),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference: the specified exchange algorithm, counting exchanges
  task automatic model_sort();
    logic [W-1:0] a;
    ref_swaps = 0;
    for (int i = 0; i < K; i++) ref_m[i] = pat[i];
    for (int i = 0; i <= K - 2; i++) begin
      a = ref_m[i];
      for (int j = i + 1; j <= K - 1; j++) begin
        if (a > ref_m[j]) begin
          ref_m[i] = ref_m[j];
          ref_m[j] = a;
          a = ref_m[i];
          ref_swaps++;
        end
      end
    end
  endtask

  function automatic int exp_cycles(input int s);
    return 2 * (K - 1) + 3 * K * (K - 1) / 2 + 2 * s;
  endfunction

  task automatic load_word(input int addr, input int val);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = AW'(addr); ld_data = W'(val);
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic read_word(input int addr, output int val);
    @(negedge clk);
    rd_addr = AW'(addr);
    @(posedge clk); @(posedge clk); @(negedge clk);
    val = int'(rd_data);
  endtask

  task automatic load_pattern();
    for (int i = 0; i < K; i++) load_word(i, int'(pat[i]));
  endtask

  // mode 0 plain, 1 load during run, 2 read sweep during run, 3 load with start
  task automatic run_sort(input int mode, output int n);
    logic [W-1:0] held;
    int bad;
    held = rd_data;
    bad = 0;
    @(negedge clk);
    start = 1'b1;
    if (mode == 3) begin ld_we = 1'b1; ld_addr = AW'(2); ld_data = 8'h05; end
    @(posedge clk);
    @(negedge clk);
    ld_we = 1'b0;
    n = 0;
    while (!done && n < 5000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (mode == 1) begin
        if (n == 4) begin ld_we = 1'b1; ld_addr = AW'(3); ld_data = 8'h00; end
        if (n == 9) ld_we = 1'b0;
      end
      if (mode == 2) begin
        rd_addr = AW'(n);
        if (rd_data != held) bad++;
      end
    end
    ld_we = 1'b0;
    if (mode == 2) check(bad == 0, "R7 rd_data frozen during run", bad, 0);
    // R4: done persists while start is held
    @(posedge clk); @(negedge clk);
    check(done == 1'b1, "R4 done held with start high", int'(done), 1);
    start = 1'b0;
    @(posedge clk); @(negedge clk);
    check(done == 1'b0, "R4 done cleared after start low", int'(done), 0);
  endtask

  task automatic verify_contents(input string tag);
    int v;
    int bad;
    bad = 0;
    for (int i = 0; i < K; i++) begin
      read_word(i, v);
      if (v != int'(ref_m[i])) begin
        bad++;
        $display("FAIL %s word %0d: actual %0d expected %0d", tag, i, v, ref_m[i]);
      end
    end
    checks = checks + 1;
    if (bad != 0) errors = errors + 1;
  endtask

  task automatic t_pattern(input string tag);
    int n;
    load_pattern();
    model_sort();
    run_sort(0, n);
    check(n == exp_cycles(ref_swaps), {"R3 run length ", tag}, n, exp_cycles(ref_swaps));
    verify_contents({"R1 order ", tag});
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(done == 1'b0, "R9 done after reset", int'(done), 0);
    check(rd_data == '0, "R9 rd_data after reset", int'(rd_data), 0);
  endtask

  task automatic t_load_read();
    int v;
    load_word(5, 8'hA7);
    read_word(5, v);
    check(v == 8'hA7, "R5 load then read word 5", v, 8'hA7);
    load_word(0, 8'h3C);
    read_word(0, v);
    check(v == 8'h3C, "R5 load then read word 0", v, 8'h3C);
  endtask

  task automatic t_equal_timing();
    int n_eq, n_sorted;
    for (int i = 0; i < K; i++) pat[i] = 8'h5A;
    load_pattern(); model_sort();
    run_sort(0, n_eq);
    verify_contents("R2 all equal contents");
    for (int i = 0; i < K; i++) pat[i] = W'(i * 9 + 1);
    load_pattern(); model_sort();
    run_sort(0, n_sorted);
    check(n_eq == n_sorted, "R2 equal words cost no exchange", n_eq, n_sorted);
    check(n_eq == exp_cycles(0), "R2 R3 no-exchange run length", n_eq, exp_cycles(0));
  endtask

  task automatic t_load_busy();
    int n;
    for (int i = 0; i < K; i++) pat[i] = W'(80 - 10 * i);
    load_pattern(); model_sort();
    run_sort(1, n);
    verify_contents("R6 load during run ignored");
  endtask

  task automatic t_read_hold();
    int v, n;
    for (int i = 0; i < K; i++) pat[i] = W'((i * 53 + 17) ^ (i << 2));
    load_pattern(); model_sort();
    read_word(4, v);
    run_sort(2, n);
    verify_contents("R7 contents after read sweep");
  endtask

  task automatic t_load_with_start();
    int n;
    for (int i = 0; i < K; i++) pat[i] = W'(200 - 7 * i);
    load_pattern();
    pat[2] = 8'h05;
    model_sort();
    run_sort(3, n);
    check(n == exp_cycles(ref_swaps), "R8 run length with same-cycle load", n, exp_cycles(ref_swaps));
    verify_contents("R8 load with start included");
  endtask

  task automatic t_rerun();
    int n;
    // memory already ordered from the previous run; a new run changes nothing
    for (int i = 0; i < K; i++) pat[i] = ref_m[i];
    model_sort();
    run_sort(0, n);
    check(n == exp_cycles(0), "R10 rerun on ordered data", n, exp_cycles(0));
    verify_contents("R10 rerun contents");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load_read();
    for (int i = 0; i < K; i++) pat[i] = W'(K - i);
    t_pattern("reversed");
    for (int i = 0; i < K; i++) pat[i] = W'((i * 37 + 11) ^ (i << 3));
    t_pattern("scrambled");
    pat[0] = 3; pat[1] = 1; pat[2] = 3; pat[3] = 2;
    pat[4] = 1; pat[5] = 3; pat[6] = 0; pat[7] = 2;
    t_pattern("duplicates");
    for (int i = 0; i < K; i++) pat[i] = (i % 2 == 0) ? 8'hFF : 8'h00;
    t_pattern("extremes");
    t_equal_timing();
    t_load_busy();
    t_read_hold();
    t_load_with_start();
    t_rerun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule